// File: doc/BRIEF.md
# Converter Readout Controller

This block is the host-side master for a byte-wide integrating analog-to-digital converter. The converter reports its progress on a two-bit status code. A client issues one of three commands on a small command port: run a conversion, program a new mode byte, or run an auto-zero. The controller then drives the converter's active-low convert, active-low output-enable and active-low auto-zero strobes, the active-high mode-control line and the byte it places on the shared data bus. It holds each strobe for a programmed minimum number of clock cycles and waits on the status code. Each wait has its own timeout.

For a conversion it collects three bytes, most significant first, into a 24-bit offset-binary word. It also produces the signed equivalent by subtracting the midpoint code of the resolution that is active (18, 20, 22 or 24 bits). The controller tracks that resolution itself. A mode write that succeeds updates it, and an auto-zero returns it to the converter's power-up setting of 22 bits. Every delay and timeout is a parameter in clock cycles. The default values assume a 100 MHz clock.

Top module: `rdo_ctl`

## Requirements
- R1: A command is taken only when `busy` is low and `cmd_valid` is high with `cmd_op` nonzero. The encoding is 01 = convert, 10 = write mode, 11 = auto-zero, 00 = nothing. `busy` rises on the cycle after acceptance and stays high until the sequence ends. Commands presented while `busy` is high are ignored.
- R2: A conversion issues exactly three `conv_n` low pulses, each exactly CONV_PW cycles long. After the first pulse the controller waits for status 01, after the second for 10 and after the third for 11.
- R3: Each byte read holds `oe_n` low for exactly OE_DLY cycles and samples `bus_in` on the last of them. Outside a mode write, `oe_n` and `conv_n` are never low together.
- R4: `result_raw` holds the three bytes in arrival order: first byte in bits 23:16, second in 15:8, third in 7:0. `result_valid` rises when the third byte is taken and clears when the next command is accepted.
- R5: `result_signed` equals `result_raw` minus 2^(N-1), where N is the active resolution. It is held as a 24-bit two's-complement value.
- R6: A mode write runs in this order. First it drives `cmd_mode` on `bus_out` with `bus_drive` and `mode_ctl` high. Then it drives `oe_n` low. Then it drives `conv_n` low and holds it until the status has left 11 and come back to 11. Then it releases `conv_n` and `oe_n` together. Only after that does it drop `mode_ctl` and `bus_drive`.
- R7: Mode byte bits 2:0 select the resolution: 001 = 18, 010 = 20, 011 = 22, 100 = 24. `active_res` reports these as 0, 1, 2 and 3. Any other code leaves the resolution unchanged. `active_res` changes only through an accepted command.
- R8: An auto-zero holds `az_n` low for exactly AZ_PW cycles. It then waits for the status to leave 11 and return to 11. `active_res` becomes 2 (22 bits).
- R9: If any status wait exceeds its timeout, `err` is set and every strobe is released. `busy` falls and a failed mode write leaves `active_res` unchanged. `err` clears when the next command is accepted.
- R10: While reset is high and just after it, `busy`, `err`, `result_valid`, `mode_ctl` and `bus_drive` are low, `conv_n`, `oe_n` and `az_n` are high, and `active_res` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (01 convert, 10 mode write, 11 auto-zero) |
| cmd_mode | input | 8 | Mode byte for a mode write |
| busy | output | 1 | A sequence is running |
| err | output | 1 | The last sequence ended on a timeout |
| conv_n | output | 1 | Convert strobe, active low |
| oe_n | output | 1 | Output-enable strobe, active low |
| mode_ctl | output | 1 | Mode-control line, active high |
| az_n | output | 1 | Auto-zero strobe, active low |
| bus_out | output | 8 | Mode byte driven onto the data bus |
| bus_drive | output | 1 | Host drives `bus_out` onto the bus |
| bus_in | input | 8 | Data bus as read from the converter |
| status_in | input | 2 | Converter status code (asynchronous) |
| active_res | output | 2 | Resolution in force (0 = 18 bits to 3 = 24 bits) |
| result_valid | output | 1 | A complete result is held |
| result_raw | output | 24 | Offset-binary result |
| result_signed | output | 24 | Two's-complement result |

## Verification
The hardest situations to reach are the middle of a mode write and a status wait that expires. Both depend on how the converter answers, not on anything the command port can drive. The bench contains a behavioural converter that lowers its status on each convert or auto-zero edge and restores it after a set delay. A mute switch freezes it, which drives the controller into its timeout paths during both a conversion and a mode write. While the controller is busy, the bench presents competing commands and counts strobe edges to show that they were dropped.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 3;
  localparam int WORD_W  = BYTE_W * N_BYTES;

  typedef enum logic [1:0] {
    RES18 = 2'd0,
    RES20 = 2'd1,
    RES22 = 2'd2,
    RES24 = 2'd3
  } res_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CONV = 2'd1,
    OP_MODE = 2'd2,
    OP_AZ   = 2'd3
  } op_t;

  localparam logic [1:0] STAT_READY = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CV_PULSE,
    ST_CV_WAIT,
    ST_RD_OE,
    ST_MW_SETUP,
    ST_MW_OE,
    ST_MW_DROP,
    ST_MW_RISE,
    ST_MW_REL,
    ST_AZ_PULSE,
    ST_AZ_DROP,
    ST_AZ_RISE
  } state_t;

  function automatic res_t mode_to_res(input logic [2:0] code, input res_t cur);
    case (code)
      3'd1:    return RES18;
      3'd2:    return RES20;
      3'd3:    return RES22;
      3'd4:    return RES24;
      default: return cur;
    endcase
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rdo_sync.sv
module rdo_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rdo_timer.sv
module rdo_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/rdo_word_asm.sv
module rdo_word_asm #(
  parameter int BW = 8,
  parameter int NB = 3,
  localparam int WW = BW * NB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [BW-1:0] byte_in,
  output logic [WW-1:0] word,
  output logic [WW-1:0] word_nx
);
  assign word_nx = {word[WW-BW-1:0], byte_in};

  always_ff @(posedge clk) begin
    if (rst)      word <= '0;
    else if (cap) word <= word_nx;
  end
endmodule

// File: rtl/rdo_signer.sv
module rdo_signer
  import rdo_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] raw,
  input  res_t         res,
  output logic [W-1:0] sval
);
  logic [W-1:0] mid;
  int           sh;

  always_comb begin
    sh   = W - 1 - 2 * (int'(RES24) - int'(res));
    mid  = {{(W-1){1'b0}}, 1'b1} << sh;
    sval = raw - mid;
  end
endmodule

// File: rtl/rdo_ctl.sv
module rdo_ctl
  import rdo_pkg::*;
#(
  parameter int CONV_PW  = 600,
  parameter int OE_DLY   = 5,
  parameter int SETUP    = 2,
  parameter int STAT_TO  = 1000,
  parameter int BYTE_TO  = 500,
  parameter int CONV_TO  = 120_000_000,
  parameter int MODE_TO  = 300_000,
  parameter int AZ_PW    = 25,
  parameter int AZ_TO    = 60_000_000,
  parameter int SYNC_STG = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [BYTE_W-1:0]    cmd_mode,
  output logic                 busy,
  output logic                 err,
  output logic                 conv_n,
  output logic                 oe_n,
  output logic                 mode_ctl,
  output logic                 az_n,
  output logic [BYTE_W-1:0]    bus_out,
  output logic                 bus_drive,
  input  logic [BYTE_W-1:0]    bus_in,
  input  logic [1:0]           status_in,
  output logic [1:0]           active_res,
  output logic                 result_valid,
  output logic [WORD_W-1:0]    result_raw,
  output logic [WORD_W-1:0]    result_signed
);
  localparam int TMAX = imax(imax(imax(CONV_PW, OE_DLY), imax(SETUP, STAT_TO)),
                             imax(imax(BYTE_TO, CONV_TO), imax(imax(MODE_TO, AZ_PW), AZ_TO)));
  localparam int TW = $clog2(TMAX + 1);

  localparam logic [TW-1:0] L_CONV_PW = TW'(CONV_PW - 1);
  localparam logic [TW-1:0] L_OE      = TW'(OE_DLY - 1);
  localparam logic [TW-1:0] L_SETUP   = TW'(SETUP - 1);
  localparam logic [TW-1:0] L_STAT    = TW'(STAT_TO - 1);
  localparam logic [TW-1:0] L_BYTE    = TW'(BYTE_TO - 1);
  localparam logic [TW-1:0] L_CONV_TO = TW'(CONV_TO - 1);
  localparam logic [TW-1:0] L_MODE_TO = TW'(MODE_TO - 1);
  localparam logic [TW-1:0] L_AZ_PW   = TW'(AZ_PW - 1);
  localparam logic [TW-1:0] L_AZ_TO   = TW'(AZ_TO - 1);
  localparam logic [1:0]    LAST_IDX  = 2'(N_BYTES - 1);

  state_t              st_q, st_n;
  logic [1:0]          idx_q;
  logic [1:0]          stat_s;
  logic [1:0]          want;
  logic                t_load, t_zero;
  logic [TW-1:0]       t_val;
  logic                accept, cap, fin, to_err, idx_inc, mode_commit;
  res_t                res_q;
  logic [BYTE_W-1:0]   mode_q;
  logic [WORD_W-1:0]   word_q, word_nx, sval_nx;

  rdo_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(STAT_READY)) u_sync (
    .clk(clk), .rst(rst), .d(status_in), .q(stat_s)
  );

  rdo_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  rdo_word_asm #(.BW(BYTE_W), .NB(N_BYTES)) u_asm (
    .clk(clk), .rst(rst), .cap(cap), .byte_in(bus_in),
    .word(word_q), .word_nx(word_nx)
  );

  rdo_signer #(.W(WORD_W)) u_sgn (
    .raw(word_nx), .res(res_q), .sval(sval_nx)
  );

  assign want = idx_q + 2'd1;

  always_comb begin
    st_n        = st_q;
    t_load      = 1'b0;
    t_val       = '0;
    accept      = 1'b0;
    cap         = 1'b0;
    fin         = 1'b0;
    to_err      = 1'b0;
    idx_inc     = 1'b0;
    mode_commit = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid && op_t'(cmd_op) != OP_NONE) begin
          accept = 1'b1;
          t_load = 1'b1;
          case (op_t'(cmd_op))
            OP_CONV: begin st_n = ST_CV_PULSE; t_val = L_CONV_PW; end
            OP_MODE: begin st_n = ST_MW_SETUP; t_val = L_SETUP;   end
            default: begin st_n = ST_AZ_PULSE; t_val = L_AZ_PW;   end
          endcase
        end
      end
      ST_CV_PULSE: begin
        if (t_zero) begin
          st_n   = ST_CV_WAIT;
          t_load = 1'b1;
          t_val  = (idx_q == 2'd0) ? L_CONV_TO : L_BYTE;
        end
      end
      ST_CV_WAIT: begin
        if (stat_s == want) begin
          st_n = ST_RD_OE; t_load = 1'b1; t_val = L_OE;
        end else if (t_zero) begin
          st_n = ST_IDLE; to_err = 1'b1;
        end
      end
      ST_RD_OE: begin
        if (t_zero) begin
          cap = 1'b1;
          if (idx_q == LAST_IDX) begin
            st_n = ST_IDLE; fin = 1'b1;
          end else begin
            idx_inc = 1'b1;
            st_n    = ST_CV_PULSE; t_load = 1'b1; t_val = L_CONV_PW;
          end
        end
      end
      ST_MW_SETUP: begin
        if (t_zero) begin st_n = ST_MW_OE; t_load = 1'b1; t_val = L_SETUP; end
      end
      ST_MW_OE: begin
        if (t_zero) begin st_n = ST_MW_DROP; t_load = 1'b1; t_val = L_STAT; end
      end
      ST_MW_DROP: begin
        if (stat_s != STAT_READY) begin
          st_n = ST_MW_RISE; t_load = 1'b1; t_val = L_MODE_TO;
        end else if (t_zero) begin
          st_n = ST_IDLE; to_err = 1'b1;
        end
      end
      ST_MW_RISE: begin
        if (stat_s == STAT_READY) begin
          st_n = ST_MW_REL; t_load = 1'b1; t_val = L_SETUP;
        end else if (t_zero) begin
          st_n = ST_IDLE; to_err = 1'b1;
        end
      end
      ST_MW_REL: begin
        if (t_zero) begin st_n = ST_IDLE; mode_commit = 1'b1; end
      end
      ST_AZ_PULSE: begin
        if (t_zero) begin st_n = ST_AZ_DROP; t_load = 1'b1; t_val = L_STAT; end
      end
      ST_AZ_DROP: begin
        if (stat_s != STAT_READY) begin
          st_n = ST_AZ_RISE; t_load = 1'b1; t_val = L_AZ_TO;
        end else if (t_zero) begin
          st_n = ST_IDLE; to_err = 1'b1;
        end
      end
      ST_AZ_RISE: begin
        if (stat_s == STAT_READY) begin
          st_n = ST_IDLE;
        end else if (t_zero) begin
          st_n = ST_IDLE; to_err = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      idx_q         <= 2'd0;
      err           <= 1'b0;
      result_valid  <= 1'b0;
      result_signed <= '0;
      res_q         <= RES22;
      mode_q        <= '0;
      busy          <= 1'b0;
      conv_n        <= 1'b1;
      oe_n          <= 1'b1;
      az_n          <= 1'b1;
      mode_ctl      <= 1'b0;
      bus_drive     <= 1'b0;
    end else begin
      st_q <= st_n;
      if (accept)       idx_q <= 2'd0;
      else if (idx_inc) idx_q <= idx_q + 2'd1;

      if (accept)      err <= 1'b0;
      else if (to_err) err <= 1'b1;

      if (accept)   result_valid <= 1'b0;
      else if (fin) result_valid <= 1'b1;
      if (fin) result_signed <= sval_nx;

      if (accept && op_t'(cmd_op) == OP_MODE) mode_q <= cmd_mode;
      if (accept && op_t'(cmd_op) == OP_AZ)   res_q  <= RES22;
      else if (mode_commit)                   res_q  <= mode_to_res(mode_q[2:0], res_q);

      busy      <= (st_n != ST_IDLE);
      conv_n    <= !(st_n inside {ST_CV_PULSE, ST_MW_DROP, ST_MW_RISE});
      oe_n      <= !(st_n inside {ST_RD_OE, ST_MW_OE, ST_MW_DROP, ST_MW_RISE});
      az_n      <= (st_n != ST_AZ_PULSE);
      mode_ctl  <= (st_n inside {ST_MW_SETUP, ST_MW_OE, ST_MW_DROP, ST_MW_RISE, ST_MW_REL});
      bus_drive <= (st_n inside {ST_MW_SETUP, ST_MW_OE, ST_MW_DROP, ST_MW_RISE, ST_MW_REL});
    end
  end

  assign bus_out    = mode_q;
  assign active_res = res_q;
  assign result_raw = word_q;
endmodule

// File: rtl/rdo_ctl_chk.sv
module rdo_ctl_chk #(
  parameter int CONV_PW = 600,
  parameter int AZ_PW   = 25
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       conv_n,
  input logic       oe_n,
  input logic       az_n,
  input logic       mode_ctl,
  input logic       bus_drive,
  input logic       result_valid,
  input logic [1:0] active_res
);
  logic [31:0] conv_run, az_run;
  logic        take;

  assign take = cmd_valid && (cmd_op != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_run <= '0;
      az_run   <= '0;
    end else begin
      conv_run <= conv_n ? 32'd0 : conv_run + 32'd1;
      az_run   <= az_n   ? 32'd0 : az_run + 32'd1;
    end
  end

  // R1
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && take) |=> busy);
  // R1
  a_r1_stay_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !take) |=> !busy);
  // R2
  a_r2_conv_width: assert property (@(posedge clk) disable iff (rst)
    ($rose(conv_n) && !$past(mode_ctl)) |-> (conv_run == 32'(CONV_PW)));
  // R3
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !conv_n) |-> (mode_ctl && bus_drive));
  // R4
  a_r4_valid_idle: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy);
  // R6
  a_r6_mode_drop_last: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_ctl) |-> (oe_n && conv_n));
  // R7
  a_r7_res_stable: assert property (@(posedge clk) disable iff (rst)
    (!busy && !take) |=> $stable(active_res));
  // R8
  a_r8_az_width: assert property (@(posedge clk) disable iff (rst)
    $rose(az_n) |-> (az_run == 32'(AZ_PW)));
  // R9
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (conv_n && oe_n && az_n && !mode_ctl && !bus_drive));
endmodule

bind rdo_ctl rdo_ctl_chk #(.CONV_PW(CONV_PW), .AZ_PW(AZ_PW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy),
  .conv_n(conv_n), .oe_n(oe_n), .az_n(az_n), .mode_ctl(mode_ctl),
  .bus_drive(bus_drive), .result_valid(result_valid), .active_res(active_res)
);

// File: tb/sim_rdo_ctl.sv
module sim_rdo_ctl;
  localparam int CONV_PW = 6;
  localparam int OE_DLY  = 3;
  localparam int AZ_PW   = 4;
  localparam int M_CONV  = 40;
  localparam int M_STEP  = 3;
  localparam int M_MODE  = 30;
  localparam int M_AZ    = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [7:0]  cmd_mode = 8'h00;
  logic        busy, err, conv_n, oe_n, mode_ctl, az_n, bus_drive, result_valid;
  logic [7:0]  bus_out, bus_in;
  logic [1:0]  active_res;
  logic [23:0] result_raw, result_signed;

  always #5 clk = ~clk;

  // behavioural converter
  logic [1:0]  m_st = 2'b11, m_nxt = 2'b11;
  int          m_dly = 0;
  logic        m_conv_q = 1'b1, m_az_q = 1'b1;
  logic [23:0] m_word = 24'h0;
  logic [7:0]  m_mode = 8'h00;
  bit          mute = 1'b0;
  int          ritual_bad = 0;

  assign bus_in = oe_n ? 8'h00 :
                  (m_st == 2'b01) ? m_word[23:16] :
                  (m_st == 2'b10) ? m_word[15:8]  :
                  (m_st == 2'b11) ? m_word[7:0]   : 8'h00;

  rdo_ctl #(
    .CONV_PW(CONV_PW), .OE_DLY(OE_DLY), .SETUP(2), .STAT_TO(20), .BYTE_TO(30),
    .CONV_TO(200), .MODE_TO(100), .AZ_PW(AZ_PW), .AZ_TO(300), .SYNC_STG(2)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mode(cmd_mode),
    .busy(busy), .err(err), .conv_n(conv_n), .oe_n(oe_n), .mode_ctl(mode_ctl),
    .az_n(az_n), .bus_out(bus_out), .bus_drive(bus_drive), .bus_in(bus_in),
    .status_in(m_st), .active_res(active_res), .result_valid(result_valid),
    .result_raw(result_raw), .result_signed(result_signed)
  );

  always @(posedge clk) begin
    m_conv_q <= conv_n;
    m_az_q   <= az_n;
    if (rst) begin
      m_st <= 2'b11; m_dly <= 0;
    end else if (m_dly > 0) begin
      m_dly <= m_dly - 1;
      if (m_dly == 1) m_st <= m_nxt;
    end else if (m_conv_q && !conv_n && !mute) begin
      if (mode_ctl) begin
        m_mode <= bus_out;
        if (oe_n || !bus_drive) ritual_bad <= ritual_bad + 1;
        m_st <= 2'b00; m_nxt <= 2'b11; m_dly <= M_MODE;
      end else begin
        case (m_st)
          2'b11: begin m_st <= 2'b00; m_nxt <= 2'b01; m_dly <= M_CONV; end
          2'b01: begin m_nxt <= 2'b10; m_dly <= M_STEP; end
          2'b10: begin m_nxt <= 2'b11; m_dly <= M_STEP; end
          default: ;
        endcase
      end
    end else if (m_az_q && !az_n && !mute) begin
      m_st <= 2'b00; m_nxt <= 2'b11; m_dly <= M_AZ;
    end
  end

  // strobe width monitors
  logic conv_p = 1'b1, oe_p = 1'b1, az_p = 1'b1, mode_p = 1'b0;
  int   conv_run = 0, oe_run = 0, az_run = 0;
  int   conv_bad = 0, oe_bad = 0, az_last = 0, conv_falls = 0, az_falls = 0;

  always @(posedge clk) begin
    conv_p <= conv_n; oe_p <= oe_n; az_p <= az_n; mode_p <= mode_ctl;
    if (!rst) begin
      if (conv_p && !conv_n) conv_falls <= conv_falls + 1;
      if (az_p && !az_n)     az_falls   <= az_falls + 1;
      if (!conv_n) conv_run <= conv_run + 1;
      else begin
        if (!conv_p && !mode_p && conv_run != CONV_PW) conv_bad <= conv_bad + 1;
        conv_run <= 0;
      end
      if (!oe_n) oe_run <= oe_run + 1;
      else begin
        if (!oe_p && !mode_p && oe_run != OE_DLY) oe_bad <= oe_bad + 1;
        oe_run <= 0;
      end
      if (!az_n) az_run <= az_run + 1;
      else begin
        if (!az_p) az_last <= az_run;
        az_run <= 0;
      end
    end
  end

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_mode = m;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, req, 32'(busy), 32'd0);
  endtask

  // {mode byte, raw word, expected signed}
  localparam logic [55:0] VEC [11] = '{
    {8'h04, 24'h800000, 24'h000000},
    {8'h04, 24'h000000, 24'h800000},
    {8'h04, 24'hFFFFFF, 24'h7FFFFF},
    {8'h01, 24'h020000, 24'h000000},
    {8'h01, 24'h03FFFF, 24'h01FFFF},
    {8'h01, 24'h000000, 24'hFE0000},
    {8'h02, 24'h080001, 24'h000001},
    {8'h02, 24'h07FFFF, 24'hFFFFFF},
    {8'h03, 24'h200000, 24'h000000},
    {8'h03, 24'h000000, 24'hE00000},
    {8'h3B, 24'h3FFFFF, 24'h1FFFFF}
  };

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!busy && !err && !result_valid && conv_n && oe_n && az_n && !mode_ctl && !bus_drive,
        "R10 reset lines", {busy, err, result_valid, conv_n, oe_n, az_n, mode_ctl, bus_drive}, 8'b00011100);
    chk(active_res == 2'd2, "R10 reset resolution", 32'(active_res), 32'd2);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && conv_n && oe_n, "R10 after reset", {busy, conv_n, oe_n}, 3'b011);

    // R1 op 00 does nothing
    send(2'b00, 8'h00);
    chk(!busy, "R1 null op ignored", 32'(busy), 32'd0);

    // table walk: R4 R5 R6 R7
    for (int i = 0; i < 11; i++) begin
      logic [7:0]  vm;
      logic [23:0] vr, ve;
      {vm, vr, ve} = VEC[i];
      send(2'b10, vm);
      chk(busy, "R1 busy after mode accept", 32'(busy), 32'd1);
      wait_idle("R6 mode write ends");
      chk(!err, "R6 mode write no error", 32'(err), 32'd0);
      chk(m_mode == vm, "R6 mode byte seen by converter", 32'(m_mode), 32'(vm));
      chk(active_res == 2'(vm[2:0] - 3'd1), "R7 resolution select", 32'(active_res), 32'(vm[2:0] - 3'd1));
      m_word = vr;
      send(2'b01, 8'h00);
      wait_idle("R2 conversion ends");
      chk(result_valid && !err, "R4 valid after conversion", {result_valid, err}, 2'b10);
      chk(result_raw == vr, "R4 raw word", 32'(result_raw), 32'(vr));
      chk(result_signed == ve, "R5 signed word", 32'(result_signed), 32'(ve));
    end

    // R7 invalid code keeps resolution (currently 22 from 0x3B); set 24 first
    send(2'b10, 8'h04); wait_idle("R7 mode 24");
    send(2'b10, 8'h07); wait_idle("R7 invalid mode");
    chk(active_res == 2'd3 && !err, "R7 invalid code ignored", 32'(active_res), 32'd3);
    chk(m_mode == 8'h07, "R6 invalid byte still written", 32'(m_mode), 32'h07);

    // R1 commands while busy ignored; R2 three pulses
    begin
      int cf0, af0;
      cf0 = conv_falls; af0 = az_falls;
      m_word = 24'h123456;
      send(2'b01, 8'h00);
      send(2'b11, 8'h00);
      chk(busy, "R1 busy during conversion", 32'(busy), 32'd1);
      send(2'b10, 8'h01);
      wait_idle("R1 conversion with extra commands");
      chk(conv_falls - cf0 == 3, "R2 three convert pulses", 32'(conv_falls - cf0), 32'd3);
      chk(az_falls == af0, "R1 auto-zero while busy ignored", 32'(az_falls - af0), 32'd0);
      chk(active_res == 2'd3 && m_mode == 8'h07, "R1 mode while busy ignored", 32'(active_res), 32'd3);
      chk(result_raw == 24'h123456 && result_signed == 24'h923456, "R5 24-bit signed",
          32'(result_signed), 32'h923456);
    end

    // R8 auto-zero
    send(2'b11, 8'h00);
    wait_idle("R8 auto-zero ends");
    chk(active_res == 2'd2 && !err, "R8 resolution back to 22", 32'(active_res), 32'd2);
    chk(az_last == AZ_PW, "R8 auto-zero pulse width", 32'(az_last), 32'(AZ_PW));
    m_word = 24'h200000;
    send(2'b01, 8'h00); wait_idle("R8 conversion after auto-zero");
    chk(result_signed == 24'h0, "R8 midpoint after auto-zero", 32'(result_signed), 32'h0);

    // R9 timeouts
    mute = 1'b1;
    send(2'b01, 8'h00);
    wait_idle("R9 conversion timeout ends");
    chk(err && !result_valid, "R9 conversion timeout", {err, result_valid}, 2'b10);
    chk(conv_n && oe_n && az_n, "R9 strobes released", {conv_n, oe_n, az_n}, 3'b111);
    send(2'b10, 8'h01);
    wait_idle("R9 mode timeout ends");
    chk(err && active_res == 2'd2, "R9 failed mode keeps resolution", {err, active_res}, 3'b110);
    chk(!mode_ctl && !bus_drive, "R9 mode lines released", {mode_ctl, bus_drive}, 2'b00);
    mute = 1'b0;
    m_word = 24'h2ABCDE;
    send(2'b01, 8'h00);
    chk(!err, "R9 error cleared on accept", 32'(err), 32'd0);
    wait_idle("R9 recovery conversion");
    chk(result_valid && result_raw == 24'h2ABCDE, "R4 recovery result", 32'(result_raw), 32'h2ABCDE);

    // widths and ordering gathered by monitors
    chk(conv_bad == 0, "R2 convert pulse widths", 32'(conv_bad), 32'd0);
    chk(oe_bad == 0, "R3 output-enable widths", 32'(oe_bad), 32'd0);
    chk(ritual_bad == 0, "R6 mode strobe ordering", 32'(ritual_bad), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule